// File: doc/BRIEF.md
# Isochronous-Priority Transfer Scheduler

This block picks, one transaction at a time, which pending request may start a data transfer on a shared graphics-port data path. Three request sources feed it. One queue carries isochronous traffic, which may be reads or writes. The other two queues carry asynchronous reads and asynchronous writes. The isochronous class holds a contract: within every programmable window of `cfg_period` cycles it may start up to `cfg_quota` transactions. With Y bytes per transaction, the guaranteed bandwidth is quota·Y/period. The asynchronous classes get whatever slots remain.

The device reports two flags, read-buffer-full and write-buffer-full. These flags hold back only the start of a new asynchronous transfer in the matching direction. Isochronous transfers ignore both flags, so they can overtake an asynchronous request that is held off. A transfer occupies the data path for one cycle per 16-byte beat, and no flag can cut it short once it has started.

The block also watches how long the current isochronous request has waited. It raises a flag when that wait exceeds a programmable bound. It also flags any request whose size is outside 1 to 64 bytes; such a request is never granted.

Top module: `isoch_sched`

## Requirements
- R1: The isochronous class receives at most `cfg_quota` grants within one period. The budget reloads to `cfg_quota` on the first cycle of each period. The first cycle after reset starts a period. A period lasts `cfg_period` cycles, and a value of 0 is treated as 1.
- R2: Isochronous reads and writes draw on the same budget in any mix. A grant echoes the direction of the request on `gnt_write` (1 = write) and sets `gnt_iso` to 1.
- R3: Budget left unused at the end of a period is lost. After a reload the budget is exactly `cfg_quota`, whatever was spent before.
- R4: An isochronous request is granted whatever the state of `rd_buf_full` and `wr_buf_full`. It is granted ahead of asynchronous requests that are waiting.
- R5: An isochronous request that finds the budget at zero waits for the next period. While it waits, eligible asynchronous requests are granted, and at most one grant is issued per cycle.
- R6: An asynchronous read cannot start while `rd_buf_full` is 1. An asynchronous write cannot start while `wr_buf_full` is 1. Each flag gates only its own direction.
- R7: When both asynchronous directions are eligible, grants alternate between read and write. The first such choice after reset goes to the read.
- R8: A granted transfer occupies ceil(size/16) cycles, counting the grant cycle. No new grant is issued before it ends. A buffer-full flag raised during the transfer does not lengthen it.
- R9: A request size of 1 to 64 bytes is legal. A request with size 0 or above 64 is never granted. It sets `size_err` to 1 in the cycle after it is presented.
- R10: `lat_violation` is 1 once the present isochronous request has waited ungranted for more than `cfg_lat_bound` cycles. It returns to 0 after a grant or after the request is withdrawn.
- R11: `budget_left` reports the isochronous budget left after the grant decision of the previous cycle. It is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | PERIOD_W | Period length in cycles |
| cfg_quota | input | QUOTA_W | Isochronous transactions per period |
| cfg_lat_bound | input | LAT_W | Allowed isochronous wait in cycles |
| iso_valid | input | 1 | Isochronous request pending |
| iso_write | input | 1 | Isochronous request direction, 1 = write |
| iso_size | input | SIZE_W | Isochronous request size in bytes |
| ard_valid | input | 1 | Asynchronous read pending |
| ard_size | input | SIZE_W | Asynchronous read size in bytes |
| awr_valid | input | 1 | Asynchronous write pending |
| awr_size | input | SIZE_W | Asynchronous write size in bytes |
| rd_buf_full | input | 1 | Device read buffer full |
| wr_buf_full | input | 1 | Device write buffer full |
| gnt_valid | output | 1 | A transfer was granted |
| gnt_iso | output | 1 | Granted transfer is isochronous |
| gnt_write | output | 1 | Granted transfer is a write |
| gnt_size | output | SIZE_W | Size of the granted transfer |
| budget_left | output | QUOTA_W | Remaining isochronous budget |
| size_err | output | 1 | A presented request had an illegal size |
| lat_violation | output | 1 | Isochronous wait exceeded the bound |

## Verification
Two functions can act in the same cycle: the isochronous bypass of buffer-full and the per-direction flow control on asynchronous traffic. The bench provokes this by raising both buffer-full flags while all three queues hold requests. It judges the result by checking that every grant in that window is isochronous, that no asynchronous grant follows once the isochronous queue empties, and that the held-off read goes first as soon as its own flag clears. A second pairing puts an exhausted budget together with a waiting asynchronous write. There the bench checks that the write takes each slot while the latency flag climbs to 1 on exactly the cycle after the bound.

// File: rtl/isoch_sched_pkg.sv
package isoch_sched_pkg;

  localparam int unsigned XFER_MAX_BYTES = 64;
  localparam int unsigned BEAT_BYTES     = 16;
  localparam int unsigned BEAT_W         = 3;

  // legal size window for a single transaction
  function automatic logic size_legal(input int unsigned sz);
    return (sz != 0) && (sz <= XFER_MAX_BYTES);
  endfunction

  // data-path occupancy in cycles for a transaction of sz bytes
  function automatic int unsigned beats_of(input int unsigned sz);
    return (sz + BEAT_BYTES - 1) / BEAT_BYTES;
  endfunction

endpackage

// File: rtl/isoch_period_budget.sv
module isoch_period_budget #(
  parameter int unsigned PERIOD_W = 16,
  parameter int unsigned QUOTA_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [QUOTA_W-1:0]  cfg_quota,
  input  logic                take,
  output logic                period_start,
  output logic                budget_avail,
  output logic [QUOTA_W-1:0]  budget_q
);

  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] per_last;
  logic [QUOTA_W-1:0]  budget_eff;

  assign per_last     = (cfg_period == '0) ? '0 : cfg_period - PERIOD_W'(1);
  assign period_start = (cnt_q == '0);
  assign budget_eff   = period_start ? cfg_quota : budget_q;
  assign budget_avail = (budget_eff != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      budget_q <= '0;
    end else begin
      cnt_q    <= (cnt_q >= per_last) ? '0 : cnt_q + PERIOD_W'(1);
      budget_q <= budget_eff - QUOTA_W'(take);
    end
  end

  // a grant outside a period start strictly lowers the budget
  assert_budget_drain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !period_start) |=> (budget_q < $past(budget_q)));

  // after a period start the budget never exceeds the configured quota
  assert_reload_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> (budget_q <= $past(cfg_quota)));

endmodule

// File: rtl/isoch_lat_mon.sv
module isoch_lat_mon #(
  parameter int unsigned LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iso_wait,
  input  logic [LAT_W-1:0] cfg_lat_bound,
  output logic             lat_violation
);

  logic [LAT_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (iso_wait) begin
      if (wait_q != '1) wait_q <= wait_q + LAT_W'(1);
    end else begin
      wait_q <= '0;
    end
  end

  assign lat_violation = (wait_q > cfg_lat_bound);

  // the flag can only rise after a cycle of waiting
  assert_lat_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_violation) |-> $past(iso_wait));

endmodule

// File: rtl/isoch_async_rr.sv
module isoch_async_rr (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rd_elig,
  input  logic wr_elig,
  output logic pick_rd,
  output logic pick_wr
);

  logic last_wr_q;

  always_comb begin
    pick_rd = 1'b0;
    pick_wr = 1'b0;
    if (enable) begin
      if (rd_elig && wr_elig) begin
        pick_rd = last_wr_q;
        pick_wr = !last_wr_q;
      end else begin
        pick_rd = rd_elig;
        pick_wr = wr_elig;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_wr_q <= 1'b1;
    else if (pick_rd) last_wr_q <= 1'b0;
    else if (pick_wr) last_wr_q <= 1'b1;
  end

  // with both directions eligible the pick flips direction
  assert_rr_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rd_elig && wr_elig && pick_wr) |=> !(enable && rd_elig && wr_elig && pick_wr));

endmodule

// File: rtl/isoch_sched.sv
module isoch_sched
  import isoch_sched_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16,
  parameter int unsigned QUOTA_W  = 8,
  parameter int unsigned LAT_W    = 8,
  parameter int unsigned SIZE_W   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [QUOTA_W-1:0]  cfg_quota,
  input  logic [LAT_W-1:0]    cfg_lat_bound,
  input  logic                iso_valid,
  input  logic                iso_write,
  input  logic [SIZE_W-1:0]   iso_size,
  input  logic                ard_valid,
  input  logic [SIZE_W-1:0]   ard_size,
  input  logic                awr_valid,
  input  logic [SIZE_W-1:0]   awr_size,
  input  logic                rd_buf_full,
  input  logic                wr_buf_full,
  output logic                gnt_valid,
  output logic                gnt_iso,
  output logic                gnt_write,
  output logic [SIZE_W-1:0]   gnt_size,
  output logic [QUOTA_W-1:0]  budget_left,
  output logic                size_err,
  output logic                lat_violation
);

  localparam int unsigned BUSY_W = BEAT_W;

  // named events for the assertions
  logic iso_ok, ard_ok, awr_ok;
  logic path_free;
  logic budget_avail, period_start;
  logic ev_iso_gnt, ev_ard_gnt, ev_awr_gnt, ev_any_gnt;
  logic ard_elig, awr_elig;
  logic [SIZE_W-1:0] sel_size;
  logic [BUSY_W-1:0] busy_q, busy_d;

  assign iso_ok = size_legal(32'(iso_size));
  assign ard_ok = size_legal(32'(ard_size));
  assign awr_ok = size_legal(32'(awr_size));

  assign path_free  = (busy_q == '0);

  // isochronous: flow-control flags deliberately not consulted
  assign ev_iso_gnt = path_free && iso_valid && iso_ok && budget_avail;

  assign ard_elig = path_free && ard_valid && ard_ok && !rd_buf_full;
  assign awr_elig = path_free && awr_valid && awr_ok && !wr_buf_full;

  isoch_period_budget #(.PERIOD_W(PERIOD_W), .QUOTA_W(QUOTA_W)) u_budget (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_period   (cfg_period),
    .cfg_quota    (cfg_quota),
    .take         (ev_iso_gnt),
    .period_start (period_start),
    .budget_avail (budget_avail),
    .budget_q     (budget_left)
  );

  isoch_async_rr u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (!ev_iso_gnt),
    .rd_elig (ard_elig),
    .wr_elig (awr_elig),
    .pick_rd (ev_ard_gnt),
    .pick_wr (ev_awr_gnt)
  );

  isoch_lat_mon #(.LAT_W(LAT_W)) u_lat (
    .clk           (clk),
    .rst_n         (rst_n),
    .iso_wait      (iso_valid && !ev_iso_gnt),
    .cfg_lat_bound (cfg_lat_bound),
    .lat_violation (lat_violation)
  );

  assign ev_any_gnt = ev_iso_gnt || ev_ard_gnt || ev_awr_gnt;

  always_comb begin
    if (ev_iso_gnt)      sel_size = iso_size;
    else if (ev_awr_gnt) sel_size = awr_size;
    else                 sel_size = ard_size;
  end

  always_comb begin
    if (ev_any_gnt)          busy_d = BUSY_W'(beats_of(32'(sel_size)) - 1);
    else if (busy_q != '0)   busy_d = busy_q - BUSY_W'(1);
    else                     busy_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= '0;
      gnt_valid <= 1'b0;
      gnt_iso   <= 1'b0;
      gnt_write <= 1'b0;
      gnt_size  <= '0;
      size_err  <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      gnt_valid <= ev_any_gnt;
      gnt_iso   <= ev_iso_gnt;
      gnt_write <= ev_iso_gnt ? iso_write : ev_awr_gnt;
      gnt_size  <= ev_any_gnt ? sel_size : '0;
      size_err  <= (iso_valid && !iso_ok) || (ard_valid && !ard_ok) ||
                   (awr_valid && !awr_ok);
    end
  end

  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_iso_gnt, ev_ard_gnt, ev_awr_gnt}));

  assert_rd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ard_gnt |-> !rd_buf_full);

  assert_wr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_awr_gnt |-> !wr_buf_full);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q != '0) |-> !ev_any_gnt);

  assert_legal_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_size != '0 && 32'(gnt_size) <= XFER_MAX_BYTES));

endmodule

// File: tb/test_isoch_sched.sv
`timescale 1ns/1ps
module test_isoch_sched;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_period;
  logic [7:0]  cfg_quota;
  logic [7:0]  cfg_lat_bound;
  logic        iso_valid, iso_write;
  logic [6:0]  iso_size;
  logic        ard_valid, awr_valid;
  logic [6:0]  ard_size, awr_size;
  logic        rd_buf_full, wr_buf_full;
  logic        gnt_valid, gnt_iso, gnt_write, size_err, lat_violation;
  logic [6:0]  gnt_size;
  logic [7:0]  budget_left;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  isoch_sched i_isoch_sched (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_quota(cfg_quota),
    .cfg_lat_bound(cfg_lat_bound), .iso_valid(iso_valid), .iso_write(iso_write),
    .iso_size(iso_size), .ard_valid(ard_valid), .ard_size(ard_size),
    .awr_valid(awr_valid), .awr_size(awr_size), .rd_buf_full(rd_buf_full),
    .wr_buf_full(wr_buf_full), .gnt_valid(gnt_valid), .gnt_iso(gnt_iso),
    .gnt_write(gnt_write), .gnt_size(gnt_size), .budget_left(budget_left),
    .size_err(size_err), .lat_violation(lat_violation)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle_inputs();
    iso_valid = 0; iso_write = 0; iso_size = 7'd16;
    ard_valid = 0; ard_size = 7'd16;
    awr_valid = 0; awr_size = 7'd16;
    rd_buf_full = 0; wr_buf_full = 0;
  endtask

  // reset is released just after an edge; the next edge is period cycle 0
  task automatic do_reset(input int per, input int quota, input int lat);
    cfg_period = 16'(per); cfg_quota = 8'(quota); cfg_lat_bound = 8'(lat);
    idle_inputs();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
  endtask

  task automatic t_reset_state();
    cfg_period = 16'd8; cfg_quota = 8'd2; cfg_lat_bound = 8'd4;
    idle_inputs();
    rst_n = 0;
    repeat (3) tick();
    check("R11", budget_left, 0, "budget during reset");
    check("R11", gnt_valid, 0, "grant during reset");
    check("R9", size_err, 0, "size_err during reset");
    check("R10", lat_violation, 0, "latency flag during reset");
    rst_n = 1;
  endtask

  task automatic t_quota();
    int p1 = 0, p2 = 0;
    do_reset(20, 3, 200);
    iso_valid = 1; iso_size = 7'd16;
    for (int k = 1; k <= 40; k++) begin
      iso_write = k[0];
      tick();
      if (gnt_valid) begin
        if (k <= 20) p1++; else p2++;
        check("R2", gnt_write, k & 1, "iso direction echoed");
        check("R2", gnt_iso, 1, "grant class iso");
      end
      if (k == 1) check("R11", budget_left, 2, "budget after first grant");
      if (k == 3) check("R11", budget_left, 0, "budget exhausted");
      if (k == 21) check("R1", gnt_valid, 1, "grant right after reload");
    end
    check("R1", p1, 3, "grants in period 1");
    check("R1", p2, 3, "grants in period 2");
    idle_inputs();
  endtask

  task automatic t_no_carry();
    int cnt = 0;
    do_reset(10, 2, 200);
    repeat (10) tick();
    iso_valid = 1; iso_size = 7'd8;
    for (int k = 11; k <= 20; k++) begin
      tick();
      if (gnt_valid) cnt++;
    end
    check("R3", cnt, 2, "no carry-over of unused budget");
    idle_inputs();
  endtask

  task automatic t_bypass();
    do_reset(1000, 100, 200);
    rd_buf_full = 1; wr_buf_full = 1;
    ard_valid = 1; awr_valid = 1; iso_valid = 1; iso_size = 7'd16;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R4", gnt_iso, 1, "iso granted under buffer-full");
    end
    iso_valid = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R6", gnt_valid, 0, "async held by both full flags");
    end
    rd_buf_full = 0;
    tick();
    check("R6", gnt_valid, 1, "read starts when read flag clears");
    check("R6", gnt_write, 0, "read direction");
    rd_buf_full = 1; wr_buf_full = 0;
    tick();
    check("R6", gnt_write, 1, "write starts under read-full only");
    check("R6", gnt_valid, 1, "write grant present");
    idle_inputs();
  endtask

  task automatic t_round_robin();
    do_reset(1000, 100, 200);
    ard_valid = 1; awr_valid = 1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      check("R7", gnt_valid, 1, "async grant each cycle");
      check("R7", gnt_write, (k % 2 == 0) ? 1 : 0, "read/write alternation");
    end
    idle_inputs();
  endtask

  task automatic t_busy();
    do_reset(1000, 100, 200);
    ard_valid = 1; ard_size = 7'd64;
    tick();
    check("R8", gnt_size, 64, "long read granted");
    ard_valid = 0; iso_valid = 1; iso_size = 7'd16; rd_buf_full = 1;
    for (int k = 2; k <= 4; k++) begin
      tick();
      check("R8", gnt_valid, 0, "path busy during transfer");
    end
    tick();
    check("R8", gnt_iso, 1, "iso granted once 4 beats end");
    idle_inputs();
  endtask

  task automatic t_size();
    do_reset(1000, 100, 200);
    iso_valid = 1; iso_size = 7'd65;
    tick();
    check("R9", gnt_valid, 0, "size 65 not granted");
    check("R9", size_err, 1, "size 65 flagged");
    iso_size = 7'd64;
    tick();
    check("R9", gnt_valid, 1, "size 64 granted");
    check("R9", size_err, 0, "size 64 legal");
    iso_valid = 0; ard_valid = 1; ard_size = 7'd0;
    repeat (4) tick();
    check("R9", size_err, 1, "size 0 flagged");
    check("R9", gnt_valid, 0, "size 0 not granted");
    idle_inputs();
  endtask

  task automatic t_latency();
    do_reset(1000, 0, 5);
    iso_valid = 1; iso_size = 7'd16; awr_valid = 1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      check("R5", gnt_write && gnt_valid && !gnt_iso, 1, "async write uses slot");
      check("R10", lat_violation, (k > 5) ? 1 : 0, "latency flag timing");
    end
    iso_valid = 0;
    tick();
    check("R10", lat_violation, 0, "flag clears on withdraw");
    idle_inputs();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_quota();
    t_no_carry();
    t_bypass();
    t_round_robin();
    t_busy();
    t_size();
    t_latency();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule